// File: doc/BRIEF.md
# Asynchronous Multiplexed-Address Host Bus Slave

This block connects an asynchronous host processor bus to a synchronous internal register and buffer port. The host places a 15-bit address on its address lines and marks it valid with an address-latch-enable strobe. It then runs a read or a write with separate active-low read and write strobes, all qualified by an active-low chip select. The block captures the address when the latch enable falls. It brings chip select and the strobes into the core clock through synchronizer chains. For each strobe assertion it issues exactly one request on an internal request/acknowledge port whose latency is not fixed.

For a read, the active-low ready output stays high, meaning not ready, until the internal port has returned the data. The data is then placed on the host data bus and ready is pulled low. The host ends the cycle by raising the read strobe, and the block releases the bus. A write samples the host data bus while the write strobe is low, forwards address and data as one request, and pulls ready low once that request is acknowledged. The 8-bit host data bus is presented as separate input, output and output-enable signals, so the pad buffer sits at chip level.

The control is one state machine with five states: `ST_IDLE`, `ST_RD_REQ`, `ST_RD_DONE`, `ST_WR_REQ` and `ST_WR_DONE`. Its transitions are:
- IDLE to RD_REQ on a synchronized read-strobe fall, while the mode is selected and chip select is active.
- IDLE to WR_REQ on a synchronized write-strobe fall when no read-strobe fall occurs in the same cycle.
- RD_REQ to RD_DONE, and WR_REQ to WR_DONE, on acknowledge.
- RD_DONE to IDLE when the synchronized read strobe is high, chip select goes inactive, or the mode is deselected.
- WR_DONE to IDLE when the synchronized write strobe is high, chip select goes inactive, or the mode is deselected.

Top module: `hostbus_async_slave`

## Requirements
- R1: Only mode-select code 3'b000 enables the block. With any other code no internal request is issued, ready stays high and the data output enable stays low.
- R2: While chip select (active low) is high, strobe falls are ignored: no request is issued and ready stays high.
- R3: The address is tracked while latch enable is high and held from its falling edge. The address must stay stable for 3 core clocks after that edge. Later changes on the address lines do not alter the address carried by the request.
- R4: A read-strobe fall issues one request with write flag 0. The request stays asserted until acknowledge. The returned data is presented on the data output while ready is low.
- R5: Ready becomes low only in the cycle after acknowledge. While ready is high during a read, the data output enable is low.
- R6: Within 4 core clocks of the read strobe returning high, the data output enable is low and ready is high.
- R7: With data bus enable (active low) held high during a read, ready still goes low but the data output enable stays low.
- R8: A write-strobe fall issues one request with write flag 1, the latched address and the data sampled from the bus. Ready goes low after acknowledge and returns high within 4 core clocks of the write strobe rising.
- R9: A strobe held low after its access completes issues no further request.
- R10: When the read and write strobes fall in the same core clock, only the read is performed.
- R11: After reset, ready is high, the output enable is low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Bus mode select; 3'b000 enables this slave |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch enable; the address is held on its fall |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dben_n | input | 1 | Data bus enable for reads, active low |
| host_addr | input | 15 | Host address lines |
| host_d_in | input | 8 | Data lines as seen from the pad |
| host_d_out | output | 8 | Read data toward the pad |
| host_d_oe | output | 1 | Pad output enable |
| rdy_n | output | 1 | Ready, active low |
| req | output | 1 | Internal request, held until acknowledge |
| req_we | output | 1 | Request is a write |
| req_addr | output | 15 | Request address |
| req_wdata | output | 8 | Request write data |
| ack | input | 1 | Internal acknowledge, one-cycle pulse |
| ack_rdata | input | 8 | Read data, valid with acknowledge |

## Verification
The hardest situation to reach is two strobe edges that land in the same core clock after synchronization, along with strobes that stay low long after their access has finished. Both depend on host timing relative to the core clock, not on any single input value. The bench drives both strobes on the same falling clock edge so that they leave the synchronizers together. It also keeps strobes low for many cycles after ready, while the responder acknowledges with a random latency of zero to five cycles.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_DONE,
        ST_WR_REQ,
        ST_WR_DONE
    } hb_state_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_addr_hold.sv
module hb_addr_hold #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_s,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    // transparent while the synchronized enable is high, frozen once it drops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr_q <= '0;
        else if (ale_s) addr_q <= addr_in;
    end
endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ok,
    input  logic              cs_act,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic              dben_s,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ack,
    input  logic [DATA_W-1:0] ack_rdata,
    output logic              req,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_hold,
    output logic              drive_en,
    output logic              rdy_n
);
    hb_state_t state, nxt;
    logic      rd_prev, wr_prev;
    logic      rd_fall, wr_fall, go;

    assign rd_fall = rd_prev & ~rd_s;
    assign wr_fall = wr_prev & ~wr_s;
    assign go      = mode_ok & cs_act;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (go && rd_fall)      nxt = ST_RD_REQ;
                        else if (go && wr_fall) nxt = ST_WR_REQ;
            ST_RD_REQ:  if (ack) nxt = ST_RD_DONE;
            ST_RD_DONE: if (rd_s || !go) nxt = ST_IDLE;
            ST_WR_REQ:  if (ack) nxt = ST_WR_DONE;
            ST_WR_DONE: if (wr_s || !go) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rd_prev <= 1'b1;
            wr_prev <= 1'b1;
        end else begin
            state   <= nxt;
            rd_prev <= rd_s;
            wr_prev <= wr_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_we    <= 1'b0;
            req_addr  <= '0;
            req_wdata <= '0;
            rd_hold   <= '0;
        end else begin
            if (state == ST_IDLE && nxt == ST_RD_REQ) begin
                req_we   <= 1'b0;
                req_addr <= addr_q;
            end else if (state == ST_IDLE && nxt == ST_WR_REQ) begin
                req_we    <= 1'b1;
                req_addr  <= addr_q;
                req_wdata <= data_in;
            end
            if (state == ST_RD_REQ && ack) rd_hold <= ack_rdata;
        end
    end

    always_comb begin
        req      = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        rdy_n    = !((state == ST_RD_DONE) || (state == ST_WR_DONE));
        drive_en = (state == ST_RD_DONE) && !dben_s && mode_ok;
    end

    assert_mode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> mode_ok);
    assert_cs_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !cs_act) |=> (state == ST_IDLE));
    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> $stable(req_addr));
    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);
    assert_rdy_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(ack));
    assert_single_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> $past(ack));
endmodule

// File: rtl/hostbus_async_slave.sv
module hostbus_async_slave #(
    parameter int                ADDR_W      = 15,
    parameter int                DATA_W      = 8,
    parameter int                MODE_W      = 3,
    parameter int                SYNC_STAGES = 2,
    parameter logic [MODE_W-1:0] MODE_CODE   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              dben_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_d_in,
    output logic [DATA_W-1:0] host_d_out,
    output logic              host_d_oe,
    output logic              rdy_n,
    output logic              req,
    output logic              req_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              ack,
    input  logic [DATA_W-1:0] ack_rdata
);
    localparam int          NCTL    = 5;
    localparam logic [NCTL-1:0] CTL_IDLE = 5'b10111; // cs_n, ale, rd_n, wr_n, dben_n

    logic [NCTL-1:0] ctl_s;
    logic            cs_s, ale_s, rd_s, wr_s, dben_s;
    logic [ADDR_W-1:0] addr_q;
    logic            mode_ok;

    assign mode_ok = (mode_sel == MODE_CODE);

    hb_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, ale, rd_n, wr_n, dben_n}),
        .q     (ctl_s)
    );
    assign {cs_s, ale_s, rd_s, wr_s, dben_s} = ctl_s;

    hb_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ale_s   (ale_s),
        .addr_in (host_addr),
        .addr_q  (addr_q)
    );

    hb_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_ok   (mode_ok),
        .cs_act    (~cs_s),
        .rd_s      (rd_s),
        .wr_s      (wr_s),
        .dben_s    (dben_s),
        .addr_q    (addr_q),
        .data_in   (host_d_in),
        .ack       (ack),
        .ack_rdata (ack_rdata),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_hold   (host_d_out),
        .drive_en  (host_d_oe),
        .rdy_n     (rdy_n)
    );
endmodule

// File: tb/hostbus_async_slave_tb.sv
module hostbus_async_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'b000;
    logic        cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, dben_n = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_d_in = '0;
    logic [7:0]  host_d_out;
    logic        host_d_oe, rdy_n, req, req_we, ack;
    logic [14:0] req_addr;
    logic [7:0]  req_wdata, ack_rdata;

    int n_chk = 0, n_bad = 0, n_req = 0;
    logic        last_we;
    logic [14:0] last_addr;
    logic [7:0]  last_wdata;
    int wait_cnt = 0, lat = 2;

    always #4 clk = ~clk;

    hostbus_async_slave u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .dben_n(dben_n), .host_addr(host_addr),
        .host_d_in(host_d_in), .host_d_out(host_d_out), .host_d_oe(host_d_oe),
        .rdy_n(rdy_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .ack_rdata(ack_rdata)
    );

    function automatic logic [7:0] mem_val(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
    endfunction

    // internal responder with random latency
    always @(posedge clk) begin
        ack <= 1'b0;
        if (!rst_n) begin
            wait_cnt <= 0;
        end else if (req && !ack) begin
            if (wait_cnt >= lat) begin
                ack        <= 1'b1;
                ack_rdata  <= mem_val(req_addr);
                last_we    <= req_we;
                last_addr  <= req_addr;
                last_wdata <= req_wdata;
                n_req      <= n_req + 1;
                wait_cnt   <= 0;
                lat        <= int'($urandom % 6);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic put_addr(input logic [14:0] a);
        host_addr = a; cs_n = 1'b0; ale = 1'b1;
        ticks(3);
        ale = 1'b0;
        ticks(4);
        host_addr = ~a;   // later address changes must not matter (R3)
    endtask

    task automatic wait_rdy(output bit got, input bit chk_oe);
        got = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!rdy_n) begin got = 1; break; end
            if (chk_oe) check(host_d_oe == 1'b0, "R5 oe while not ready", host_d_oe, 0);
        end
    endtask

    task automatic host_read(input logic [14:0] a, input int hold);
        int base; bit got;
        put_addr(a);
        base = n_req;
        rd_n = 1'b0;
        wait_rdy(got, 1);
        check(got, "R4 ready seen", got, 1);
        check(host_d_oe && host_d_out == mem_val(a), "R4 read data", host_d_out, mem_val(a));
        check(last_addr == a && last_we == 1'b0, "R3 latched read addr", last_addr, a);
        ticks(hold);
        check(n_req - base == 1, "R9 one request per read", n_req - base, 1);
        rd_n = 1'b1;
        ticks(4);
        check(!host_d_oe && rdy_n, "R6 bus released", {host_d_oe, rdy_n}, 2'b01);
        cs_n = 1'b1;
        ticks(3);
    endtask

    task automatic host_write(input logic [14:0] a, input logic [7:0] d, input int hold);
        int base; bit got;
        put_addr(a);
        base = n_req;
        host_d_in = d;
        wr_n = 1'b0;
        wait_rdy(got, 0);
        check(got, "R8 write ready", got, 1);
        check(last_we && last_addr == a && last_wdata == d, "R8 write req", {last_addr, last_wdata}, {a, d});
        ticks(hold);
        check(n_req - base == 1, "R9 one request per write", n_req - base, 1);
        wr_n = 1'b1;
        ticks(4);
        check(rdy_n, "R8 ready released", rdy_n, 1);
        host_d_in = 8'hxx ^ 8'h00;
        host_d_in = ~d;
        cs_n = 1'b1;
        ticks(3);
    endtask

    // {write, address, data}
    localparam logic [23:0] VEC [10] = '{
        {1'b1, 15'h0000, 8'h11}, {1'b0, 15'h0000, 8'h00},
        {1'b1, 15'h7FFF, 8'hFF}, {1'b0, 15'h7FFF, 8'h00},
        {1'b0, 15'h2A55, 8'h00}, {1'b1, 15'h1234, 8'hA5},
        {1'b0, 15'h4001, 8'h00}, {1'b1, 15'h0080, 8'h00},
        {1'b0, 15'h5555, 8'h00}, {1'b1, 15'h3C3C, 8'h96}
    };

    initial begin
        ticks(20000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base; bit got;
        ticks(3);
        check(rdy_n && !host_d_oe && !req, "R11 reset state", {rdy_n, host_d_oe, req}, 3'b100);
        rst_n = 1'b1;
        ticks(3);

        for (int v = 0; v < 10; v++) begin
            if (VEC[v][23]) host_write(VEC[v][22:8], VEC[v][7:0], v % 3);
            else            host_read(VEC[v][22:8], v % 3);
        end

        // R9: strobes held long after completion
        host_read(15'h0F0F, 25);
        host_write(15'h7001, 8'h3C, 25);

        // R1: other mode codes
        mode_sel = 3'b010;
        put_addr(15'h0100);
        base = n_req;
        rd_n = 1'b0;
        ticks(30);
        check(n_req == base && rdy_n && !host_d_oe, "R1 mode deselected", n_req - base, 0);
        rd_n = 1'b1; cs_n = 1'b1; mode_sel = 3'b000;
        ticks(4);

        // R2: chip select inactive
        host_addr = 15'h0200; ale = 1'b1; ticks(3); ale = 1'b0; ticks(4);
        base = n_req;
        wr_n = 1'b0; ticks(30);
        check(n_req == base && rdy_n, "R2 write ignored without cs", n_req - base, 0);
        wr_n = 1'b1; rd_n = 1'b0; ticks(30);
        check(n_req == base && rdy_n, "R2 read ignored without cs", n_req - base, 0);
        rd_n = 1'b1; ticks(4);

        // R7: data bus enable high during read
        dben_n = 1'b1;
        put_addr(15'h0333);
        rd_n = 1'b0;
        wait_rdy(got, 1);
        check(got && !host_d_oe, "R7 no drive without dben", host_d_oe, 0);
        rd_n = 1'b1; ticks(4);
        cs_n = 1'b1; dben_n = 1'b0; ticks(3);

        // R10: both strobes fall together
        put_addr(15'h0444);
        base = n_req;
        host_d_in = 8'hC3;
        rd_n = 1'b0; wr_n = 1'b0;
        wait_rdy(got, 1);
        check(got && last_we == 1'b0 && host_d_out == mem_val(15'h0444), "R10 read wins", last_we, 0);
        ticks(10);
        check(n_req - base == 1, "R10 single request", n_req - base, 1);
        rd_n = 1'b1; wr_n = 1'b1; ticks(6);
        check(n_req - base == 1 && rdy_n && !host_d_oe, "R10 write dropped", n_req - base, 1);
        cs_n = 1'b1; ticks(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule